// File: doc/BRIEF.md
# Secondary Interrupt Combiner with Direct Routing

This block gathers 32 interrupt request lines and presents them to a primary interrupt controller. Each input's level is captured in a raw level register. An enable mask selects which raw levels take part in a single combined request. That request is OR-reduced and driven on upstream line 31. Ten of the inputs, indices 21 to 30, can also bypass the combiner. When an input's routing-enable bit is set, the upstream line with the same index follows that input directly.

Software reaches the block through a simple word-addressed register bus of 1024 words (4 KB). The bus has a select, a write strobe, a word index, write data and combinational read data. The mask and the routing enable are each changed through separate set and clear words, so several agents can update them without read-modify-write races. A pair of soft words sets or clears mask bit 0 on any nonzero write. All state and all upstream outputs are registered. They change on the clock edge that samples an input change or a write.

Top module: `sic_passthru`

## Requirements
- R1: The raw level register captures `irq_in` on every clock edge. Word 1 reads it back.
- R2: `up_irq[31]` is high, one clock after the sampled inputs and writes, exactly when (raw level AND mask) is nonzero.
- R3: Word 0 reads raw level AND mask. Word 2 reads the mask. Word 8 reads the routing enable. Word 4 reads raw level bit 0 in bit 0, with all other bits zero.
- R4: A write to word 2 ORs the write data into the mask. A write to word 3 clears every mask bit that is set in the write data.
- R5: A write to word 8 ORs only write-data bits 21 to 30 (0x7FE00000) into the routing enable. All other data bits are ignored.
- R6: A write to word 9 clears every routing-enable bit that is set in the write data.
- R7: For i in 21..30, `up_irq[i]` equals routing-enable bit i AND raw level bit i, registered one clock after the change.
- R8: A nonzero write to word 4 sets mask bit 0, and a zero write to word 4 has no effect. A nonzero write to word 5 clears mask bit 0, and a zero write to word 5 has no effect.
- R9: Reads of words other than 0, 1, 2, 4 and 8 return zero. Writes to words other than 2, 3, 4, 5, 8 and 9 change no state.
- R10: Reset clears level, mask and routing enable and drives all outputs low. `up_irq[20:0]` is always low.
- R11: A read in the same cycle as a write returns the state as it stood before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Incoming interrupt levels |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe (with bus_sel) |
| bus_word | input | 10 | Word index within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (zero when not selected) |
| up_irq | output | 32 | Upstream lines: 31 combined, 21..30 routed, rest low |

## Verification
The checker watches several relations on every cycle:
- the raw level tracks the previous cycle's inputs;
- line 31 matches the masked level;
- the routed lines equal routing enable AND level;
- the routing enable never holds bits outside 21..30;
- lines 0 to 20 stay low.

Other behaviour shows only in the bench's scenarios. This covers the meaning of each register word under set, clear and soft writes, including zero-valued soft writes. It also covers writes and reads at undefined words, the pre-write value seen by a same-cycle read, and the reset state.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int SIC_W     = 32;
    localparam int WORD_W    = 10;
    localparam int PT_LO     = 21;
    localparam int PT_HI     = 30;
    localparam int COMB_LINE = 31;

    localparam logic [SIC_W-1:0] PT_MASK =
        ((SIC_W'(1) << (PT_HI + 1)) - 1) & ~((SIC_W'(1) << PT_LO) - 1);

    localparam logic [WORD_W-1:0] W_MSTAT   = 10'd0;
    localparam logic [WORD_W-1:0] W_RAW     = 10'd1;
    localparam logic [WORD_W-1:0] W_MSET    = 10'd2;
    localparam logic [WORD_W-1:0] W_MCLR    = 10'd3;
    localparam logic [WORD_W-1:0] W_SOFTSET = 10'd4;
    localparam logic [WORD_W-1:0] W_SOFTCLR = 10'd5;
    localparam logic [WORD_W-1:0] W_PSET    = 10'd8;
    localparam logic [WORD_W-1:0] W_PCLR    = 10'd9;

    typedef struct packed {
        logic [SIC_W-1:0] level;
        logic [SIC_W-1:0] mask;
        logic [SIC_W-1:0] pen;
    } sic_regs_t;
endpackage

// File: rtl/sic_route.sv
module sic_route
    import sic_pkg::*;
(
    input  logic [SIC_W-1:0] level,
    input  logic [SIC_W-1:0] mask,
    input  logic [SIC_W-1:0] pen,
    output logic [SIC_W-1:0] up
);
    for (genvar i = 0; i < SIC_W; i++) begin : g_line
        if (i == COMB_LINE) begin : g_comb
            assign up[i] = |(level & mask);
        end else if (i >= PT_LO && i <= PT_HI) begin : g_pass
            assign up[i] = level[i] & pen[i];
        end else begin : g_off
            assign up[i] = 1'b0;
        end
    end
endmodule

// File: rtl/sic_rdmux.sv
module sic_rdmux
    import sic_pkg::*;
(
    input  logic              sel,
    input  logic [WORD_W-1:0] word,
    input  logic [SIC_W-1:0]  level,
    input  logic [SIC_W-1:0]  mask,
    input  logic [SIC_W-1:0]  pen,
    output logic [SIC_W-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        if (sel) begin
            case (word)
                W_MSTAT:   rdata = level & mask;
                W_RAW:     rdata = level;
                W_MSET:    rdata = mask;
                W_SOFTSET: rdata = {{(SIC_W-1){1'b0}}, level[0]};
                W_PSET:    rdata = pen;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/sic_passthru.sv
module sic_passthru
    import sic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SIC_W-1:0]  irq_in,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_word,
    input  logic [SIC_W-1:0]  bus_wdata,
    output logic [SIC_W-1:0]  bus_rdata,
    output logic [SIC_W-1:0]  up_irq
);
    sic_regs_t        regs_d, regs_q;
    logic [SIC_W-1:0] up_d, up_q;
    logic [SIC_W-1:0] lvl_w, msk_w, pen_w;
    logic             wr;

    assign wr = bus_sel & bus_we;

    always_comb begin
        regs_d       = regs_q;
        regs_d.level = irq_in;
        if (wr) begin
            case (bus_word)
                W_MSET:    regs_d.mask = regs_q.mask | bus_wdata;
                W_MCLR:    regs_d.mask = regs_q.mask & ~bus_wdata;
                W_SOFTSET: if (|bus_wdata) regs_d.mask[0] = 1'b1;
                W_SOFTCLR: if (|bus_wdata) regs_d.mask[0] = 1'b0;
                W_PSET:    regs_d.pen  = regs_q.pen | (bus_wdata & PT_MASK);
                W_PCLR:    regs_d.pen  = regs_q.pen & ~bus_wdata;
                default:   ;
            endcase
        end
    end

    sic_route u_route (
        .level (regs_d.level),
        .mask  (regs_d.mask),
        .pen   (regs_d.pen),
        .up    (up_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
            up_q   <= '0;
        end else begin
            regs_q <= regs_d;
            up_q   <= up_d;
        end
    end

    assign lvl_w  = regs_q.level;
    assign msk_w  = regs_q.mask;
    assign pen_w  = regs_q.pen;
    assign up_irq = up_q;

    sic_rdmux u_rd (
        .sel   (bus_sel),
        .word  (bus_word),
        .level (lvl_w),
        .mask  (msk_w),
        .pen   (pen_w),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/sic_checker.sv
module sic_checker
    import sic_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [SIC_W-1:0] irq_in,
    input logic [SIC_W-1:0] up_irq,
    input logic [SIC_W-1:0] level_q,
    input logic [SIC_W-1:0] mask_q,
    input logic [SIC_W-1:0] pen_q
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_level_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (level_q == $past(irq_in)));

    p_comb_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        up_irq[COMB_LINE] == (|(level_q & mask_q)));

    p_pen_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pen_q & ~PT_MASK) == '0);

    p_routed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_irq & PT_MASK) == (level_q & pen_q & PT_MASK));

    p_low_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
        up_irq[PT_LO-1:0] == '0);
endmodule

bind sic_passthru sic_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .up_irq  (up_irq),
    .level_q (lvl_w),
    .mask_q  (msk_w),
    .pen_q   (pen_w)
);

// File: tb/tb_sic_passthru.sv
module tb_sic_passthru;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] up_irq;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sic_passthru dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_word(bus_word), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .up_irq(up_irq)
    );

    typedef struct packed {
        logic [31:0] irq;
        logic [9:0]  ww;
        logic [31:0] wd;
        logic [9:0]  rw;
        logic [31:0] rx;
        logic [31:0] ux;
        logic [7:0]  req;
    } vec_t;

    // each row: drive irq and write (ww, wd) together, then read word rw
    localparam vec_t VEC [12] = '{
        '{32'h0000_0001, 10'd2, 32'h0000_0001, 10'd0, 32'h0000_0001, 32'h8000_0000, 8'd4},  // R4 R2
        '{32'h0000_0001, 10'd3, 32'h0000_0001, 10'd2, 32'h0000_0000, 32'h0000_0000, 8'd4},  // R4
        '{32'h0000_0000, 10'd4, 32'h0000_0005, 10'd2, 32'h0000_0001, 32'h0000_0000, 8'd8},  // R8 soft set
        '{32'h0000_0001, 10'd7, 32'hFFFF_FFFF, 10'd4, 32'h0000_0001, 32'h8000_0000, 8'd3},  // R3 R9
        '{32'h0000_0001, 10'd5, 32'h0000_0000, 10'd2, 32'h0000_0001, 32'h8000_0000, 8'd8},  // R8 zero
        '{32'h0000_0001, 10'd5, 32'h0000_0002, 10'd2, 32'h0000_0000, 32'h0000_0000, 8'd8},  // R8 clear
        '{32'hFFFF_FFFF, 10'd8, 32'hFFFF_FFFF, 10'd8, 32'h7FE0_0000, 32'h7FE0_0000, 8'd5},  // R5 R7
        '{32'h0060_0000, 10'd9, 32'h0020_0000, 10'd8, 32'h7FC0_0000, 32'h0040_0000, 8'd6},  // R6 R7
        '{32'h0060_0000, 10'd2, 32'h0020_0000, 10'd0, 32'h0020_0000, 32'h8040_0000, 8'd2},  // R2 R3
        '{32'h0060_0000, 10'd6, 32'h0000_FFFF, 10'd1, 32'h0060_0000, 32'h8040_0000, 8'd1},  // R1 R9
        '{32'h0000_0000, 10'd9, 32'hFFFF_FFFF, 10'd12, 32'h0000_0000, 32'h0000_0000, 8'd9}, // R9 read
        '{32'h8000_0010, 10'd2, 32'h8000_0000, 10'd0, 32'h8000_0000, 32'h8000_0000, 8'd10}  // R10 low lines
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [9:0] w, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_word = w;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [9:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        irq_in = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R10 up during reset", up_irq, 32'h0);
        rst_n = 1'b1;
        irq_in = '0;
        @(negedge clk);
        check("R10 up after reset", up_irq, 32'h0);
        rd(10'd1, v); check("R10 raw reset", v, 32'h0);
        rd(10'd2, v); check("R10 mask reset", v, 32'h0);
        rd(10'd8, v); check("R10 routing reset", v, 32'h0);

        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            irq_in = VEC[i].irq;
            bus_sel = 1'b1; bus_we = 1'b1;
            bus_word = VEC[i].ww; bus_wdata = VEC[i].wd;
            @(negedge clk);
            bus_we = 1'b0; bus_word = VEC[i].rw;
            #1;
            n_run++;
            if (bus_rdata !== VEC[i].rx || up_irq !== VEC[i].ux) begin
                n_fail++;
                $display("FAIL R%0d row %0d: actual rd %h up %h expected rd %h up %h",
                         VEC[i].req, i, bus_rdata, up_irq, VEC[i].rx, VEC[i].ux);
            end
            bus_sel = 1'b0;
        end

        // R11: read of mask in the same cycle as a set write shows old value
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_word = 10'd2; bus_wdata = 32'h0000_0004;
        #1 check("R11 pre-write read", bus_rdata, 32'h8020_0000);
        @(negedge clk);
        bus_we = 1'b0;
        #1 check("R11 post-write read", bus_rdata, 32'h8020_0004);
        bus_sel = 1'b0;

        // R1 R7: level changes alone move routed line and combined output
        wr(10'd8, 32'h4000_0000);
        irq_in = 32'h4000_0000;
        @(negedge clk);
        check("R7 routed line 30", up_irq, 32'h4000_0000);
        irq_in = 32'h0020_0000;
        @(negedge clk);
        check("R2 combined on bit21", up_irq, 32'h8000_0000);

        // R10: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R10 async reset up", up_irq, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        irq_in = '0;
        rd(10'd2, v); check("R10 mask cleared", v, 32'h0);
        rd(10'd8, v); check("R10 routing cleared", v, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule